// File: doc/BRIEF.md
# Round-Robin Sample-and-Hold Refresh Sequencer

This block drives the refresh of a bank of sample-and-hold output channels that share one DAC. A refresh clock, taken from an internal divider of the system clock or from an external clock pin, paces the work. On each falling edge of that refresh clock the channel pointer moves to the next channel. The selected channel's code is routed to the shared DAC, and its switch-enable bit is raised for the whole low phase. The switches open again at the next rising edge, so every channel is revisited once per `NCH` refresh cycles. A new code for a channel therefore reaches its output within 1 to `NCH` refresh cycles.

The clock source is chosen at run time by a configuration write. After reset the internal source is in use and the clock pin is not driven. The pin only starts to carry the internal refresh clock after internal mode has been written explicitly. It can then serve as the external clock of a second device. Source changes are deferred until both candidate clocks are low, so no runt phase appears. While the external source is in use, each phase is timed in system-clock cycles. A phase that is too short sets a sticky flag, and a too-short high phase cancels the sample window that follows it.

Top module: `sh_refresh_seq`

## Requirements
- R1: While reset is held and right after it, `sw_en` is 0, `cur_ch` is `NCH-1`, `osc_oe` is 0, `phase_viol` is 0 and the internal source is in use.
- R2: Each falling edge of the active refresh clock advances `cur_ch` by one, wrapping from `NCH-1` to 0. The new value appears one system cycle after the edge is seen.
- R3: `sw_en` is either zero or has exactly one set bit, at index `cur_ch`. It is set from the cycle after a falling edge until the cycle after the next rising edge, and it is never set while the active refresh clock was high in the previous cycle.
- R4: `dac_code` always equals bits `[cur_ch*DW +: DW]` of `codes`, so a changed code is presented at that channel's next turn.
- R5: The internal refresh clock, visible on `osc_out`, starts low after reset and toggles every `HALF_DIV` system cycles.
- R6: A write with `cfg_ext`=1 requests the external source and `cfg_ext`=0 requests the internal one. The request takes effect only in a cycle where both the internal clock and the twice-synchronised `osc_in` are low. The external input reaches the sequencer through a two-flop synchroniser.
- R7: `osc_oe` is 0 from reset until a write with `cfg_ext`=0 occurs. After that it is 1 exactly while the internal source is both requested and active.
- R8: While the external source is active, any `osc_in` phase shorter than `MIN_PHASE` system cycles sets `phase_viol`, which stays set until reset. A short high phase suppresses the sample window after it, but the pointer still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ext | input | 1 | Source request written by `cfg_we`: 1 external, 0 internal |
| codes | input | NCH*DW | Per-channel codes, channel i at bits `[i*DW +: DW]` |
| osc_in | input | 1 | External refresh clock from the pin |
| osc_out | output | 1 | Internal refresh clock toward the pin |
| osc_oe | output | 1 | Pin output enable |
| dac_code | output | DW | Code of the selected channel for the shared DAC |
| sw_en | output | NCH | One-hot sample switch enables |
| cur_ch | output | CW | Selected channel index |
| phase_viol | output | 1 | Sticky short external phase flag |

## Verification
If the pointer goes wrong, `cur_ch` and `dac_code` disagree with the reference at the next falling edge, one refresh period at most. A wrong window flag shows on `sw_en` within one system cycle of an edge. A source switch at the wrong moment shifts every later edge, so it is caught within one phase. Errors in pin control or violation timing show directly on `osc_oe` and `phase_viol`, within a cycle of the write or the offending edge.

// File: rtl/sh_refresh_seq.sv
module sh_refresh_seq #(
  parameter int NCH = 10,
  parameter int DW = 10,
  parameter int HALF_DIV = 1190,
  parameter int MIN_PHASE = 200,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int DIVW = $clog2(HALF_DIV + 1),
  localparam int PHW = $clog2(MIN_PHASE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_ext,
  input  logic [NCH*DW-1:0] codes,
  input  logic              osc_in,
  output logic              osc_out,
  output logic              osc_oe,
  output logic [DW-1:0]     dac_code,
  output logic [NCH-1:0]    sw_en,
  output logic [CW-1:0]     cur_ch,
  output logic              phase_viol
);

  logic [DIVW-1:0] div_cnt;
  logic [PHW-1:0]  ph_cnt;
  logic int_clk, ext_s1, ext_s2, ext_q;
  logic req_ext, sel_ext, wrote_int;
  logic rclk, rclk_q, in_win;
  logic fall, rise, ext_edge, short_ph;
  logic [CW-1:0] ptr;

  assign rclk     = sel_ext ? ext_s2 : int_clk;
  assign fall     = rclk_q & ~rclk;
  assign rise     = ~rclk_q & rclk;
  assign ext_edge = ext_s2 ^ ext_q;
  assign short_ph = ext_edge && (ph_cnt < PHW'(MIN_PHASE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      int_clk <= 1'b0;
    end else if (div_cnt == DIVW'(HALF_DIV - 1)) begin
      div_cnt <= '0;
      int_clk <= ~int_clk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_s1 <= 1'b0;
      ext_s2 <= 1'b0;
      ext_q  <= 1'b0;
      rclk_q <= 1'b0;
    end else begin
      ext_s1 <= osc_in;
      ext_s2 <= ext_s1;
      ext_q  <= ext_s2;
      rclk_q <= rclk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ext   <= 1'b0;
      wrote_int <= 1'b0;
      sel_ext   <= 1'b0;
    end else begin
      if (cfg_we) begin
        req_ext <= cfg_ext;
        if (!cfg_ext) wrote_int <= 1'b1;
      end
      if (sel_ext != req_ext && !int_clk && !ext_s2) sel_ext <= req_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_cnt     <= PHW'(MIN_PHASE);
      phase_viol <= 1'b0;
    end else begin
      if (ext_edge) ph_cnt <= PHW'(1);
      else if (ph_cnt < PHW'(MIN_PHASE)) ph_cnt <= ph_cnt + 1'b1;
      if (sel_ext && short_ph) phase_viol <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= CW'(NCH - 1);
      in_win <= 1'b0;
    end else if (fall) begin
      ptr    <= (ptr == CW'(NCH - 1)) ? '0 : ptr + 1'b1;
      in_win <= !(sel_ext && short_ph);
    end else if (rise) begin
      in_win <= 1'b0;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_sw
    assign sw_en[g] = in_win && (ptr == CW'(g));
  end

  assign dac_code = codes[int'(ptr)*DW +: DW];
  assign cur_ch   = ptr;
  assign osc_out  = int_clk;
  assign osc_oe   = wrote_int && !req_ext && !sel_ext;

endmodule

module sh_refresh_seq_chk #(
  parameter int NCH = 10,
  parameter int CW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] sw_en,
  input logic [CW-1:0]  cur_ch,
  input logic           phase_viol,
  input logic           sel_ext,
  input logic           int_clk,
  input logic           ext_s2,
  input logic           rclk
);

  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_en));

  a_r3_at_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_en) |-> sw_en[cur_ch]);

  a_r3_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_en) |-> !$past(rclk));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ch != $past(cur_ch)) |->
      (cur_ch == (($past(cur_ch) == CW'(NCH - 1)) ? '0 : CW'($past(cur_ch) + 1'b1))));

  a_r6_switch_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ext != $past(sel_ext)) |-> (!$past(int_clk) && !$past(ext_s2)));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(phase_viol) |-> phase_viol);

endmodule

bind sh_refresh_seq sh_refresh_seq_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .cur_ch(cur_ch),
  .phase_viol(phase_viol), .sel_ext(sel_ext), .int_clk(int_clk),
  .ext_s2(ext_s2), .rclk(rclk)
);

// File: tb/sh_refresh_seq_tb.sv
module sh_refresh_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 10;
  localparam int DW = 10;
  localparam int HD = 3;
  localparam int MP = 3;
  localparam int CW = $clog2(NCH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_ext = 1'b0, osc_in = 1'b0;
  logic [NCH*DW-1:0] codes;
  logic osc_out, osc_oe, phase_viol;
  logic [DW-1:0] dac_code;
  logic [NCH-1:0] sw_en;
  logic [CW-1:0] cur_ch;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  int m_div, m_ptr, m_ph;
  bit m_int, m_s1, m_s2, m_q, m_req, m_wint, m_sel, m_rq, m_win, m_viol;

  sh_refresh_seq #(.NCH(NCH), .DW(DW), .HALF_DIV(HD), .MIN_PHASE(MP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ext(cfg_ext), .codes(codes),
    .osc_in(osc_in), .osc_out(osc_out), .osc_oe(osc_oe), .dac_code(dac_code),
    .sw_en(sw_en), .cur_ch(cur_ch), .phase_viol(phase_viol));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_div = 0; m_ptr = NCH - 1; m_ph = MP;
    {m_int, m_s1, m_s2, m_q, m_req, m_wint, m_sel, m_rq, m_win, m_viol} = '0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit rc, fl, rs, ed, sh, n_int, n_sel;
      int n_div;
      rc = m_sel ? m_s2 : m_int;
      fl = m_rq && !rc;
      rs = !m_rq && rc;
      ed = (m_s2 != m_q);
      sh = ed && (m_ph < MP);
      n_div = (m_div == HD - 1) ? 0 : m_div + 1;
      n_int = (m_div == HD - 1) ? !m_int : m_int;
      n_sel = (m_sel != m_req && !m_int && !m_s2) ? m_req : m_sel;
      if (m_sel && sh) m_viol = 1;
      m_ph = ed ? 1 : (m_ph < MP ? m_ph + 1 : m_ph);
      if (fl) begin
        m_ptr = (m_ptr + 1) % NCH;
        m_win = !(m_sel && sh);
      end else if (rs) m_win = 0;
      if (cfg_we) begin
        m_req = cfg_ext;
        if (!cfg_ext) m_wint = 1;
      end
      m_sel = n_sel; m_div = n_div; m_int = n_int;
      m_q = m_s2; m_s2 = m_s1; m_s1 = osc_in; m_rq = rc;
    end
    #1;
    if (rst_n && !done) begin
      chk(m_sel ? "R6" : "R2", "cur_ch", cur_ch, m_ptr);
      chk("R3", "sw_en", sw_en, m_win ? (64'd1 << m_ptr) : 0);
      chk("R4", "dac_code", dac_code, codes[m_ptr*DW +: DW]);
      chk("R5", "osc_out", osc_out, m_int);
      chk("R7", "osc_oe", osc_oe, m_wint && !m_req && !m_sel);
      chk("R8", "phase_viol", phase_viol, m_viol);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(bit ext);
    cfg_ext = ext; cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic ext_run(int halves, int half_len);
    for (int i = 0; i < halves; i++) begin
      osc_in = ~osc_in;
      tick(half_len);
    end
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) codes[i*DW +: DW] = DW'((i * 97 + 5) % 1024);
    tick(3);
    chk("R1", "sw_en in reset", sw_en, 0);
    chk("R1", "cur_ch in reset", cur_ch, NCH - 1);
    chk("R1", "osc_oe in reset", osc_oe, 0);
    chk("R1", "phase_viol in reset", phase_viol, 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1", "cur_ch after reset", cur_ch, NCH - 1);
    tick(150);
    cfg(1'b0);
    tick(150);
    codes[4*DW +: DW] = 10'h3ff;
    codes[0 +: DW] = 10'h000;
    tick(100);
    cfg(1'b1);
    ext_run(40, 8);
    // short high phase on the external clock
    osc_in = 1'b0; tick(9);
    osc_in = 1'b1; tick(1);
    osc_in = 1'b0; tick(9);
    ext_run(20, 7);
    osc_in = 1'b0; tick(9);
    cfg(1'b0);
    ext_run(30, 6);
    tick(60);
    chk("R8", "phase_viol held", phase_viol, 1);
    chk("R7", "osc_oe back in internal", osc_oe, 1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule